// File: doc/BRIEF.md
# Length-Sorted Batch Wavelength Assigner

This block schedules a batch of packets that arrived together in one time slot onto the wavelengths of a shared delay-line buffer. A batch opens with a one-cycle `batch_start` pulse that also fixes the ordering mode. Descriptors, each a length in slots and an identifier, then follow one per cycle, and the descriptor marked `desc_last` closes the batch. While the batch is loading, an insertion sorter places each descriptor in its position at once. Sorting therefore takes no cycles beyond the load.

Once the batch is sorted, the block handles one packet per cycle in sorted order. Each packet looks up the wavelength whose queue counter is smallest. If that counter exceeds the buffer depth, the packet is dropped. Otherwise the packet takes that wavelength, the counter value becomes its delay, and the packet's length is added to the counter before the next packet looks. Every `batch_start` ages all counters by one slot. A cycle budget per slot is checked, and a flag rises if the batch has not finished within it.

The controller has four states. IDLE waits for a batch. LOAD collects descriptors. ASSIGN emits one result per cycle. FIN shows `done` for one cycle. The transitions are as follows. IDLE moves to LOAD on `batch_start`. LOAD moves to ASSIGN on a descriptor carrying `desc_last`. ASSIGN moves to FIN when the last sorted entry is processed. FIN returns to IDLE unconditionally. A `batch_start` outside IDLE is ignored.

Top module: `sorted_wl_assigner`

## Requirements
- R1: After reset, `res_valid`, `done` and `overrun` are low and every wavelength queue counter is zero.
- R2: With `longest_first`=0 captured at `batch_start`, results come out in non-decreasing `res_len`. Equal lengths keep their arrival order.
- R3: With `longest_first`=1, results come out in non-increasing `res_len`. Equal lengths keep their arrival order.
- R4: Each kept packet takes the wavelength with the smallest counter, and the lowest index wins a tie. `res_delay` equals that counter value, which is never above DEPTH.
- R5: After a kept packet, the chosen counter grows by the packet length before the next packet in the same batch is placed.
- R6: A packet whose smallest counter is above DEPTH is reported with `res_drop`=1, `res_wl`=0 and `res_delay`=0, and no counter changes.
- R7: Each accepted `batch_start` lowers every counter by one, and a counter at zero stays at zero.
- R8: A batch holds at most MAX_PKTS descriptors. Extra descriptors in the same batch produce no result.
- R9: Results appear one per cycle, starting the cycle after the `desc_last` descriptor is loaded. `done` is high for exactly one cycle, the same cycle as the final result.
- R10: `overrun` rises if the batch is still in LOAD or ASSIGN at the SLOT_BUDGET-th clock edge after the accepted `batch_start`. It stays high until the next accepted `batch_start` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| batch_start | input | 1 | Opens a batch and ages the counters (accepted in IDLE only) |
| longest_first | input | 1 | Ordering mode sampled with `batch_start`: 0 shortest first, 1 longest first |
| desc_valid | input | 1 | Descriptor present this cycle |
| desc_last | input | 1 | Marks the final descriptor of the batch |
| desc_len | input | LEN_W | Packet length in slots |
| desc_id | input | ID_W | Packet identifier |
| res_valid | output | 1 | Result present this cycle |
| res_id | output | ID_W | Identifier of the reported packet |
| res_len | output | LEN_W | Length of the reported packet |
| res_wl | output | WL_W | Chosen buffer wavelength |
| res_delay | output | DLY_W | Delay in slots given to the packet |
| res_drop | output | 1 | Packet dropped |
| done | output | 1 | Batch finished, shown with the final result |
| overrun | output | 1 | Slot budget exceeded for this batch |

## Verification
On every cycle the checker enforces the following. Length ordering holds between consecutive results for each mode. A dropped result has zeroed wavelength and delay fields. No kept delay exceeds the depth. `done` coincides with a result. The batch count stays within capacity. The block is quiet in IDLE, and `overrun` clears after a batch opens. Other properties need whole scenarios and are shown only by the bench's reference model and directed batches: the choice of the minimum counter, counters that carry over from one batch to the next with ageing, the tie-breaking rules, and the truncation of oversized batches.

// File: rtl/swa_pkg.sv
package swa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ASSIGN,
        ST_FIN
    } swa_state_e;

endpackage

// File: rtl/lsort_insert.sv
module lsort_insert #(
    parameter int NUM   = 8,
    parameter int LEN_W = 4,
    parameter int ID_W  = 6,
    localparam int CNT_W = $clog2(NUM + 1),
    localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             ins_valid,
    input  logic [LEN_W-1:0] ins_len,
    input  logic [ID_W-1:0]  ins_id,
    input  logic             descending,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [LEN_W-1:0] rd_len,
    output logic [ID_W-1:0]  rd_id,
    output logic [CNT_W-1:0] count
);

    logic [NUM-1:0][LEN_W-1:0] len_v;
    logic [NUM-1:0][ID_W-1:0]  id_v;
    logic [NUM-1:0]            stays_ahead;
    logic [CNT_W-1:0]          count_q;
    logic                      do_ins;

    assign do_ins = ins_valid && (count_q != CNT_W'(NUM));

    // an occupied slot stays ahead of the new entry when it is not strictly
    // behind it in the chosen order; equal lengths stay ahead (stable order)
    always_comb begin
        for (int i = 0; i < NUM; i++) begin
            stays_ahead[i] = (CNT_W'(i) < count_q) &&
                (descending ? (len_v[i] >= ins_len) : (len_v[i] <= ins_len));
        end
    end

    for (genvar i = 0; i < NUM; i++) begin : g_slot
        logic [LEN_W-1:0] len_r;
        logic [ID_W-1:0]  id_r;
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    len_r <= '0;
                    id_r  <= '0;
                end else if (do_ins && !stays_ahead[0]) begin
                    len_r <= ins_len;
                    id_r  <= ins_id;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    len_r <= '0;
                    id_r  <= '0;
                end else if (do_ins && !stays_ahead[i]) begin
                    if (stays_ahead[i-1]) begin
                        len_r <= ins_len;
                        id_r  <= ins_id;
                    end else begin
                        len_r <= len_v[i-1];
                        id_r  <= id_v[i-1];
                    end
                end
            end
        end
        assign len_v[i] = len_r;
        assign id_v[i]  = id_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (do_ins) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    assign rd_len = len_v[rd_idx];
    assign rd_id  = id_v[rd_idx];
    assign count  = count_q;

endmodule

// File: rtl/wl_queue_bank.sv
module wl_queue_bank #(
    parameter int NUM_WL = 4,
    parameter int QW     = 6,
    parameter int LEN_W  = 4,
    localparam int WL_W  = (NUM_WL > 1) ? $clog2(NUM_WL) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     age,
    input  logic                     add_en,
    input  logic [WL_W-1:0]          add_sel,
    input  logic [LEN_W-1:0]         add_len,
    output logic [NUM_WL-1:0][QW-1:0] q
);

    for (genvar w = 0; w < NUM_WL; w++) begin : g_wl
        logic [QW-1:0] q_r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_r <= '0;
            end else if (age) begin
                if (q_r != '0) begin
                    q_r <= q_r - QW'(1);
                end
            end else if (add_en && (add_sel == WL_W'(w))) begin
                q_r <= q_r + QW'(add_len);
            end
        end
        assign q[w] = q_r;
    end

endmodule

// File: rtl/wl_argmin.sv
module wl_argmin #(
    parameter int NUM_WL = 4,
    parameter int QW     = 6,
    localparam int WL_W  = (NUM_WL > 1) ? $clog2(NUM_WL) : 1
) (
    input  logic [NUM_WL-1:0][QW-1:0] q,
    output logic [WL_W-1:0]           min_idx,
    output logic [QW-1:0]             min_val
);

    // strict compare: the lowest index keeps a tie
    always_comb begin
        min_idx = '0;
        min_val = q[0];
        for (int w = 1; w < NUM_WL; w++) begin
            if (q[w] < min_val) begin
                min_idx = WL_W'(w);
                min_val = q[w];
            end
        end
    end

endmodule

// File: rtl/sorted_wl_assigner.sv
module sorted_wl_assigner
    import swa_pkg::*;
#(
    parameter int MAX_PKTS    = 8,
    parameter int NUM_WL      = 4,
    parameter int LEN_W       = 4,
    parameter int ID_W        = 6,
    parameter int DEPTH       = 12,
    parameter int SLOT_BUDGET = 24,
    localparam int WL_W  = (NUM_WL > 1) ? $clog2(NUM_WL) : 1,
    localparam int DLY_W = $clog2(DEPTH + 1),
    localparam int QW    = $clog2(DEPTH + (1 << LEN_W)) + 1,
    localparam int CNT_W = $clog2(MAX_PKTS + 1),
    localparam int IDX_W = (MAX_PKTS > 1) ? $clog2(MAX_PKTS) : 1,
    localparam int BUD_W = $clog2(SLOT_BUDGET + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             batch_start,
    input  logic             longest_first,
    input  logic             desc_valid,
    input  logic             desc_last,
    input  logic [LEN_W-1:0] desc_len,
    input  logic [ID_W-1:0]  desc_id,
    output logic             res_valid,
    output logic [ID_W-1:0]  res_id,
    output logic [LEN_W-1:0] res_len,
    output logic [WL_W-1:0]  res_wl,
    output logic [DLY_W-1:0] res_delay,
    output logic             res_drop,
    output logic             done,
    output logic             overrun
);

    localparam logic [QW-1:0] DEPTH_Q = QW'(DEPTH);

    swa_state_e               state_q, state_d;
    logic                     mode_q;
    logic [IDX_W-1:0]         rd_idx;
    logic [CNT_W-1:0]         sort_cnt;
    logic [LEN_W-1:0]         rd_len;
    logic [ID_W-1:0]          rd_id;
    logic [NUM_WL-1:0][QW-1:0] q;
    logic [WL_W-1:0]          min_idx;
    logic [QW-1:0]            min_val;
    logic [BUD_W-1:0]         cyc_q;
    logic                     overrun_q;
    logic                     accept_start;
    logic                     drop_now;
    logic                     last_entry;
    logic                     in_assign;

    assign accept_start = (state_q == ST_IDLE) && batch_start;
    assign in_assign    = (state_q == ST_ASSIGN);
    assign drop_now     = (min_val > DEPTH_Q);
    assign last_entry   = ((CNT_W'(rd_idx) + CNT_W'(1)) == sort_cnt);

    lsort_insert #(
        .NUM   (MAX_PKTS),
        .LEN_W (LEN_W),
        .ID_W  (ID_W)
    ) u_sort (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept_start),
        .ins_valid  ((state_q == ST_LOAD) && desc_valid),
        .ins_len    (desc_len),
        .ins_id     (desc_id),
        .descending (mode_q),
        .rd_idx     (rd_idx),
        .rd_len     (rd_len),
        .rd_id      (rd_id),
        .count      (sort_cnt)
    );

    wl_queue_bank #(
        .NUM_WL (NUM_WL),
        .QW     (QW),
        .LEN_W  (LEN_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .age     (accept_start),
        .add_en  (in_assign && !drop_now),
        .add_sel (min_idx),
        .add_len (rd_len),
        .q       (q)
    );

    wl_argmin #(
        .NUM_WL (NUM_WL),
        .QW     (QW)
    ) u_min (
        .q       (q),
        .min_idx (min_idx),
        .min_val (min_val)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (batch_start) state_d = ST_LOAD;
            ST_LOAD:   if (desc_valid && desc_last) state_d = ST_ASSIGN;
            ST_ASSIGN: if (last_entry) state_d = ST_FIN;
            ST_FIN:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // batch bookkeeping, result registers and slot budget
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= 1'b0;
            rd_idx    <= '0;
            res_valid <= 1'b0;
            res_id    <= '0;
            res_len   <= '0;
            res_wl    <= '0;
            res_delay <= '0;
            res_drop  <= 1'b0;
            cyc_q     <= '0;
            overrun_q <= 1'b0;
        end else begin
            res_valid <= in_assign;
            if (accept_start) begin
                mode_q    <= longest_first;
                rd_idx    <= '0;
                cyc_q     <= '0;
                overrun_q <= 1'b0;
            end else if (state_q != ST_IDLE) begin
                if (cyc_q != BUD_W'(SLOT_BUDGET)) begin
                    cyc_q <= cyc_q + BUD_W'(1);
                end
                if ((cyc_q == BUD_W'(SLOT_BUDGET - 1)) && (state_q != ST_FIN)) begin
                    overrun_q <= 1'b1;
                end
            end
            if (in_assign) begin
                rd_idx    <= rd_idx + IDX_W'(1);
                res_id    <= rd_id;
                res_len   <= rd_len;
                res_drop  <= drop_now;
                res_wl    <= drop_now ? '0 : min_idx;
                res_delay <= drop_now ? '0 : DLY_W'(min_val);
            end
        end
    end

    // outputs
    always_comb begin
        done    = (state_q == ST_FIN);
        overrun = overrun_q;
    end

endmodule

// File: rtl/swa_checker.sv
module swa_checker
    import swa_pkg::*;
#(
    parameter int MAX_PKTS = 8,
    parameter int LEN_W    = 4,
    parameter int WL_W     = 2,
    parameter int DLY_W    = 4,
    parameter int CNT_W    = 4,
    parameter int DEPTH    = 12
) (
    input logic             clk,
    input logic             rst_n,
    input swa_state_e       state,
    input logic             mode,
    input logic             batch_start,
    input logic [CNT_W-1:0] sort_cnt,
    input logic             res_valid,
    input logic [LEN_W-1:0] res_len,
    input logic [WL_W-1:0]  res_wl,
    input logic [DLY_W-1:0] res_delay,
    input logic             res_drop,
    input logic             done,
    input logic             overrun
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!res_valid && !done));

    // R2
    ascending_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(res_valid) && !mode) |-> (res_len >= $past(res_len)));

    // R3
    descending_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(res_valid) && mode) |-> (res_len <= $past(res_len)));

    // R4
    delay_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_drop) |-> (res_delay <= DLY_W'(DEPTH)));

    // R6
    drop_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_drop) |-> (res_wl == '0 && res_delay == '0));

    // R8
    batch_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sort_cnt <= CNT_W'(MAX_PKTS));

    // R9
    done_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> res_valid);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && batch_start) |=> !overrun);

endmodule

bind sorted_wl_assigner swa_checker #(
    .MAX_PKTS (MAX_PKTS),
    .LEN_W    (LEN_W),
    .WL_W     (WL_W),
    .DLY_W    (DLY_W),
    .CNT_W    (CNT_W),
    .DEPTH    (DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state_q),
    .mode        (mode_q),
    .batch_start (batch_start),
    .sort_cnt    (sort_cnt),
    .res_valid   (res_valid),
    .res_len     (res_len),
    .res_wl      (res_wl),
    .res_delay   (res_delay),
    .res_drop    (res_drop),
    .done        (done),
    .overrun     (overrun)
);

// File: tb/tb_sorted_wl_assigner.sv
module tb_sorted_wl_assigner;

    localparam int MAX_PKTS = 8;
    localparam int NUM_WL   = 4;
    localparam int LEN_W    = 4;
    localparam int ID_W     = 6;
    localparam int DEPTH    = 12;
    localparam int BUDGET   = 24;
    localparam int WL_W     = 2;
    localparam int DLY_W    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic batch_start = 1'b0, longest_first = 1'b0;
    logic desc_valid = 1'b0, desc_last = 1'b0;
    logic [LEN_W-1:0] desc_len = '0;
    logic [ID_W-1:0]  desc_id = '0;
    logic res_valid, res_drop, done, overrun;
    logic [ID_W-1:0]  res_id;
    logic [LEN_W-1:0] res_len;
    logic [WL_W-1:0]  res_wl;
    logic [DLY_W-1:0] res_delay;

    always #2.5 clk = ~clk;

    sorted_wl_assigner #(
        .MAX_PKTS (MAX_PKTS), .NUM_WL (NUM_WL), .LEN_W (LEN_W),
        .ID_W (ID_W), .DEPTH (DEPTH), .SLOT_BUDGET (BUDGET)
    ) dut (
        .clk (clk), .rst_n (rst_n), .batch_start (batch_start),
        .longest_first (longest_first), .desc_valid (desc_valid),
        .desc_last (desc_last), .desc_len (desc_len), .desc_id (desc_id),
        .res_valid (res_valid), .res_id (res_id), .res_len (res_len),
        .res_wl (res_wl), .res_delay (res_delay), .res_drop (res_drop),
        .done (done), .overrun (overrun)
    );

    int tests = 0;
    int fails = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_st;              // 0 idle, 1 load, 2 assign, 3 fin
    bit  m_mode;
    int  m_len[$];
    int  m_id[$];
    int  m_q[NUM_WL];
    int  m_idx, m_cyc;
    bit  m_ovr;
    bit  e_valid, e_drop, e_done;
    int  e_id, e_len, e_wl, e_dly;

    always @(posedge clk) begin
        int pst, w, t;
        if (!rst_n) begin
            m_st = 0; m_mode = 0; m_len.delete(); m_id.delete();
            foreach (m_q[k]) m_q[k] = 0;
            m_idx = 0; m_cyc = 0; m_ovr = 0;
            e_valid = 0; e_drop = 0; e_done = 0;
            e_id = 0; e_len = 0; e_wl = 0; e_dly = 0;
        end else begin
            pst = m_st;
            e_valid = 0;
            if (pst != 0) begin
                m_cyc++;
                if (m_cyc == BUDGET && (pst == 1 || pst == 2)) m_ovr = 1;
            end
            case (pst)
                0: if (batch_start) begin
                    foreach (m_q[k]) if (m_q[k] > 0) m_q[k]--;
                    m_mode = longest_first;
                    m_len.delete(); m_id.delete();
                    m_cyc = 0; m_ovr = 0; m_st = 1;
                end
                1: if (desc_valid) begin
                    if (m_len.size() < MAX_PKTS) begin
                        m_len.push_back(int'(desc_len));
                        m_id.push_back(int'(desc_id));
                    end
                    if (desc_last) begin
                        for (int p = 0; p < m_len.size(); p++)
                            for (int j = 0; j + 1 < m_len.size() - p; j++)
                                if ((!m_mode && m_len[j] > m_len[j+1]) ||
                                    (m_mode && m_len[j] < m_len[j+1])) begin
                                    t = m_len[j]; m_len[j] = m_len[j+1]; m_len[j+1] = t;
                                    t = m_id[j];  m_id[j]  = m_id[j+1];  m_id[j+1]  = t;
                                end
                        m_idx = 0; m_st = 2;
                    end
                end
                2: begin
                    w = 0;
                    for (int k = 1; k < NUM_WL; k++) if (m_q[k] < m_q[w]) w = k;
                    e_valid = 1;
                    e_id = m_id[m_idx];
                    e_len = m_len[m_idx];
                    if (m_q[w] > DEPTH) begin
                        e_drop = 1; e_wl = 0; e_dly = 0;
                    end else begin
                        e_drop = 0; e_wl = w; e_dly = m_q[w];
                        m_q[w] += m_len[m_idx];
                    end
                    m_idx++;
                    if (m_idx == m_len.size()) m_st = 3;
                end
                3: m_st = 0;
                default: m_st = 0;
            endcase
            e_done = (m_st == 3);
        end
    end

    // ---------------- per-cycle comparison and result capture ----------------
    int r_cnt;
    int r_id[16], r_len[16], r_wl[16], r_dly[16];
    bit r_drop[16];

    always @(negedge clk) begin
        if (rst_n) begin
            check(res_valid == e_valid, "R9", "res_valid", res_valid, e_valid);
            if (e_valid && res_valid) begin
                check(int'(res_id) == e_id, m_mode ? "R3" : "R2", "res_id", res_id, e_id);
                check(int'(res_len) == e_len, m_mode ? "R3" : "R2", "res_len", res_len, e_len);
                check(res_drop == e_drop, "R6", "res_drop", res_drop, e_drop);
                check(int'(res_wl) == e_wl, "R4 R5 R7", "res_wl", res_wl, e_wl);
                check(int'(res_delay) == e_dly, "R4 R5 R7", "res_delay", res_delay, e_dly);
            end
            check(done == e_done, "R9", "done", done, e_done);
            check(overrun == m_ovr, "R10", "overrun", overrun, m_ovr);
            if (res_valid && r_cnt < 16) begin
                r_id[r_cnt] = res_id; r_len[r_cnt] = res_len;
                r_wl[r_cnt] = res_wl; r_dly[r_cnt] = res_delay;
                r_drop[r_cnt] = res_drop;
                r_cnt++;
            end
        end
    end

    // ---------------- watchdog ----------------
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            fails++;
            tests++;
            $display("FAIL R9 watchdog: actual=%0d expected=%0d", wd, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    int b_len[16];
    int b_id[16];

    task automatic open_batch(input bit mode);
        @(negedge clk);
        r_cnt = 0;
        batch_start = 1'b1;
        longest_first = mode;
        @(negedge clk);
        batch_start = 1'b0;
    endtask

    task automatic load_descs(input int n, input int stall_after_first);
        for (int i = 0; i < n; i++) begin
            desc_valid = 1'b1;
            desc_len = LEN_W'(b_len[i]);
            desc_id = ID_W'(b_id[i]);
            desc_last = (i == n - 1);
            @(negedge clk);
            if (i == 0 && stall_after_first > 0) begin
                desc_valid = 1'b0;
                desc_last = 1'b0;
                for (int s = 0; s < stall_after_first; s++) @(negedge clk);
            end
        end
        desc_valid = 1'b0;
        desc_last = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_batch(input bit mode, input int n);
        open_batch(mode);
        load_descs(n, 0);
        wait_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet outputs during and after reset
        check(!res_valid && !done && !overrun, "R1", "outputs in reset",
              {res_valid, done, overrun}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!res_valid && !done && !overrun, "R1", "outputs after reset",
              {res_valid, done, overrun}, 0);

        // R5: five packets of length 2 over four empty wavelengths
        for (int i = 0; i < 5; i++) begin b_len[i] = 2; b_id[i] = i + 1; end
        run_batch(1'b0, 5);
        check(r_cnt == 5, "R9", "result count", r_cnt, 5);
        check(r_wl[3] == 3 && r_dly[3] == 0, "R4", "fourth wl", r_wl[3], 3);
        check(r_wl[4] == 0, "R5", "fifth wl", r_wl[4], 0);
        check(r_dly[4] == 2, "R5", "fifth delay", r_dly[4], 2);

        // R7: counters {4,2,2,2} age to {3,1,1,1}
        b_len[0] = 1; b_id[0] = 9;
        run_batch(1'b0, 1);
        check(r_wl[0] == 1, "R7", "aged wl", r_wl[0], 1);
        check(r_dly[0] == 1, "R7", "aged delay", r_dly[0], 1);

        // R2: ascending with ties
        b_len[0] = 4; b_len[1] = 2; b_len[2] = 4; b_len[3] = 1; b_len[4] = 2;
        for (int i = 0; i < 5; i++) b_id[i] = 10 + i;
        run_batch(1'b0, 5);
        check(r_id[0] == 13 && r_id[1] == 11 && r_id[2] == 14, "R2", "ascending head",
              r_id[1], 11);
        check(r_id[3] == 10 && r_id[4] == 12, "R2", "ascending tie tail", r_id[4], 12);

        // R3: descending with ties
        b_len[0] = 3; b_len[1] = 7; b_len[2] = 3; b_len[3] = 7; b_len[4] = 1;
        for (int i = 0; i < 5; i++) b_id[i] = 20 + i;
        run_batch(1'b1, 5);
        check(r_id[0] == 21 && r_id[1] == 23, "R3", "descending tie head", r_id[1], 23);
        check(r_id[2] == 20 && r_id[3] == 22 && r_id[4] == 24, "R3", "descending tail",
              r_id[3], 22);

        // R6: a full batch of maximum-length packets overfills the buffer
        for (int i = 0; i < MAX_PKTS; i++) begin b_len[i] = 15; b_id[i] = 30 + i; end
        run_batch(1'b1, MAX_PKTS);
        check(r_drop[0] == 0, "R6", "first kept", r_drop[0], 0);
        check(r_drop[MAX_PKTS-1] == 1, "R6", "last dropped", r_drop[MAX_PKTS-1], 1);

        // R8: two descriptors past capacity
        for (int i = 0; i < MAX_PKTS + 2; i++) begin b_len[i] = 1; b_id[i] = 40 + i; end
        run_batch(1'b0, MAX_PKTS + 2);
        check(r_cnt == MAX_PKTS, "R8", "results for oversized batch", r_cnt, MAX_PKTS);
        check(r_id[MAX_PKTS-1] == 40 + MAX_PKTS - 1, "R8", "last kept id",
              r_id[MAX_PKTS-1], 40 + MAX_PKTS - 1);

        // R10: stalled load exceeds the slot budget
        b_len[0] = 2; b_id[0] = 50; b_len[1] = 3; b_id[1] = 51;
        open_batch(1'b0);
        load_descs(2, BUDGET + 4);
        wait_done();
        check(overrun == 1'b1, "R10", "overrun after stall", overrun, 1);
        open_batch(1'b1);
        check(overrun == 1'b0, "R10", "overrun cleared", overrun, 0);
        b_len[0] = 1; b_id[0] = 52;
        load_descs(1, 0);
        wait_done();

        // random batches checked by the model each cycle
        for (int b = 0; b < 40; b++) begin
            int n;
            n = $urandom_range(1, MAX_PKTS);
            for (int i = 0; i < n; i++) begin
                b_len[i] = ($urandom_range(0, 7) == 0) ? 15 : $urandom_range(1, 3);
                b_id[i] = $urandom_range(0, 63);
            end
            run_batch(1'($urandom_range(0, 1)), n);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule